// File: doc/BRIEF.md
# Reorder Ring with Shared Result-Bus Arbitration

The block keeps the in-flight instructions of an out-of-order core in a 16-slot circular ring. A dispatch stage asks for up to four slots per cycle. Each granted slot records its kind, its destination physical register and the physical register that the destination mapped to before. Slots are handed out in program order at the tail, and each slot's index serves as its tag. Functional units return results with that tag. The ring marks the slot complete and keeps the result value, the store address and the mispredict flag. Completed slots leave from the head in program order, up to four per cycle.

Four shared result buses carry data to the waiting stations and the register file. Two kinds of traffic compete for them. One is writeback results from the execution sources. The other is the ring's own broadcast of a retiring register result. Writeback always wins, in a fixed order from the lowest source index. A writeback source that is refused keeps its request up and tries again in the next cycle. The ring's broadcasts take the buses left over. A retiring register-kind slot that finds no free bus waits, and so does everything behind it. Stores and branches retire without a bus. When a retiring branch carries the mispredict flag, every younger slot is discarded at once.

Two free-running counters support performance study. One counts the cycles in which dispatch asked for more slots than it was given. The other adds up the number of occupied buses in every cycle.

Top module: `reorder_ring`

## Requirements
- R1: After synchronous reset the ring is empty, no bus is driven, nothing retires, `flush` is low and both counters read 0.
- R2: `alloc_grant` equals the lesser of `alloc_req` and the number of free slots. Granted slot i gets tag (tail + i) mod 16, so tags wrap from 15 to 0. The kind codes are 0 for register, 1 for store and 2 for branch.
- R3: `stall_cycles` increments after every cycle in which `alloc_req` exceeds `alloc_grant`.
- R4: Writeback sources are granted in ascending source index, at most 4 per cycle. `wb_ready` is high only for granted sources.
- R5: Granted writebacks occupy buses 0 upward in source order with `bus_from_rob` low. Retiring register slots take the next buses in program order with `bus_from_rob` high, and carry their tag, destination register and stored value.
- R6: A result captured from a bus marks its slot complete from the next cycle on. Up to 4 consecutive complete slots retire per cycle in program order, and retirement stops at the first incomplete slot.
- R7: A retiring register slot needs a bus that writeback left free, and retirement stops at the first register slot that gets none. Store and branch slots retire without a bus. A retiring store presents its address on `ret_addr` and its data on `ret_data`.
- R8: When a retiring branch has the mispredict flag, `flush` rises and no younger slot retires. Allocation is refused in that cycle, the ring is empty in the next cycle, and the next allocated tag is the branch tag plus one.
- R9: After each cycle, `bus_beats` grows by the number of buses driven in that cycle.
- R10: The ring holds exactly 16 slots. When all 16 are occupied, a further request is granted 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 3 | Number of slots requested this cycle (0..4) |
| alloc_kind | input | 4x2 | Kind code per request lane |
| alloc_dest | input | 4x5 | Destination physical register per lane |
| alloc_old | input | 4x5 | Previous mapping of the destination per lane |
| alloc_grant | output | 3 | Number of lanes granted |
| alloc_tag | output | 4x4 | Tag given to each lane |
| wb_valid | input | 6 | Writeback request per source |
| wb_tag | input | 6x4 | Slot tag per source |
| wb_preg | input | 6x5 | Destination register broadcast with the result |
| wb_value | input | 6x32 | Result value or store data |
| wb_addr | input | 6x32 | Store address |
| wb_mispred | input | 6 | Branch mispredict flag |
| wb_ready | output | 6 | Source granted a bus this cycle |
| bus_valid | output | 4 | Bus carries data |
| bus_from_rob | output | 4 | Bus carries a retire broadcast |
| bus_tag | output | 4x4 | Slot tag on the bus |
| bus_preg | output | 4x5 | Physical register on the bus |
| bus_value | output | 4x32 | Value on the bus |
| ret_valid | output | 4 | Lane retires this cycle |
| ret_is_store | output | 4 | Retiring lane is a store |
| ret_old_preg | output | 4x5 | Register to return to the free list |
| ret_addr | output | 4x32 | Store address |
| ret_data | output | 4x32 | Store data |
| flush | output | 1 | Mispredicted branch retires and younger slots are discarded |
| stall_cycles | output | 32 | Cycles with requests refused |
| bus_beats | output | 32 | Accumulated count of bus occupancy |

## Verification
A skewed head or tail pointer appears at the ports in the same cycle. The bench sees the wrong grant count or wrong tags on the next request, and wrong old registers on the next retirement. A completion written to the wrong slot appears one cycle after its bus transfer, when the expected slots do not retire or do not stop. A broken priority between writeback and retire broadcasts shows in the same cycle as wrong `wb_ready`, `bus_from_rob` or bus tags. A flush that leaves stale slots shows in the next cycle through the allocation tag and any retirement of a flushed slot.

// File: rtl/reorder_ring_pkg.sv
package reorder_ring_pkg;

    localparam int unsigned PREG_W = 5;
    localparam int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        K_REG    = 2'd0,
        K_STORE  = 2'd1,
        K_BRANCH = 2'd2
    } slot_kind_e;

    typedef struct packed {
        logic              done;
        logic              mispred;
        slot_kind_e        kind;
        logic [PREG_W-1:0] dest;
        logic [PREG_W-1:0] old;
        logic [DATA_W-1:0] value;
        logic [DATA_W-1:0] addr;
    } slot_t;

    function automatic logic needs_bus(input slot_kind_e k);
        return k == K_REG;
    endfunction

endpackage

// File: rtl/ring_bus_arbiter.sv
module ring_bus_arbiter #(
    parameter int NSRC = 6,
    parameter int NBUS = 4
) (
    input  logic [NSRC-1:0]                      req,
    output logic [NSRC-1:0]                      gnt,
    output logic [NSRC-1:0][$clog2(NBUS)-1:0]    slot,
    output logic [$clog2(NBUS+1)-1:0]            used
);
    localparam int BW = $clog2(NBUS);
    localparam int CW = $clog2(NBUS + 1);

    always_comb begin
        gnt  = '0;
        slot = '0;
        used = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (req[s] && (used < CW'(NBUS))) begin
                gnt[s]  = 1'b1;
                slot[s] = BW'(used);
                used    = used + CW'(1);
            end
        end
    end
endmodule

// File: rtl/ring_retire_pick.sv
module ring_retire_pick import reorder_ring_pkg::*; #(
    parameter int DEPTH = 16,
    parameter int WAYS  = 4,
    parameter int NBUS  = 4
) (
    input  logic [$clog2(DEPTH)-1:0]          head_idx,
    input  logic [$clog2(DEPTH):0]            count,
    input  logic [DEPTH-1:0]                  done,
    input  logic [DEPTH-1:0]                  mispred,
    input  logic [DEPTH-1:0][1:0]             kind,
    input  logic [$clog2(NBUS+1)-1:0]         bus_free,
    output logic [WAYS-1:0]                   ret,
    output logic [WAYS-1:0]                   use_bus,
    output logic [$clog2(WAYS+1)-1:0]         ret_n,
    output logic                              flush
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int CW = $clog2(NBUS + 1);
    localparam int WW = $clog2(WAYS + 1);

    logic [CW-1:0] left;
    logic          stop;
    logic [AW-1:0] idx;
    slot_kind_e    k_e;

    always_comb begin
        ret     = '0;
        use_bus = '0;
        ret_n   = '0;
        flush   = 1'b0;
        stop    = 1'b0;
        left    = bus_free;
        idx     = '0;
        k_e     = K_REG;
        for (int k = 0; k < WAYS; k++) begin
            idx = head_idx + AW'(k);
            k_e = slot_kind_e'(kind[idx]);
            if (!stop) begin
                if (PW'(k) >= count || !done[idx]) begin
                    stop = 1'b1;
                end else if (needs_bus(k_e) && left == '0) begin
                    stop = 1'b1;
                end else begin
                    ret[k] = 1'b1;
                    ret_n  = ret_n + WW'(1);
                    if (needs_bus(k_e)) begin
                        use_bus[k] = 1'b1;
                        left       = left - CW'(1);
                    end
                    if (k_e == K_BRANCH && mispred[idx]) begin
                        flush = 1'b1;
                        stop  = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/reorder_ring.sv
module reorder_ring import reorder_ring_pkg::*; #(
    parameter int DEPTH = 16,
    parameter int WAYS  = 4,
    parameter int NBUS  = 4,
    parameter int NSRC  = 6
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [$clog2(WAYS+1)-1:0]              alloc_req,
    input  logic [WAYS-1:0][1:0]                   alloc_kind,
    input  logic [WAYS-1:0][PREG_W-1:0]            alloc_dest,
    input  logic [WAYS-1:0][PREG_W-1:0]            alloc_old,
    output logic [$clog2(WAYS+1)-1:0]              alloc_grant,
    output logic [WAYS-1:0][$clog2(DEPTH)-1:0]     alloc_tag,
    input  logic [NSRC-1:0]                        wb_valid,
    input  logic [NSRC-1:0][$clog2(DEPTH)-1:0]     wb_tag,
    input  logic [NSRC-1:0][PREG_W-1:0]            wb_preg,
    input  logic [NSRC-1:0][DATA_W-1:0]            wb_value,
    input  logic [NSRC-1:0][DATA_W-1:0]            wb_addr,
    input  logic [NSRC-1:0]                        wb_mispred,
    output logic [NSRC-1:0]                        wb_ready,
    output logic [NBUS-1:0]                        bus_valid,
    output logic [NBUS-1:0]                        bus_from_rob,
    output logic [NBUS-1:0][$clog2(DEPTH)-1:0]     bus_tag,
    output logic [NBUS-1:0][PREG_W-1:0]            bus_preg,
    output logic [NBUS-1:0][DATA_W-1:0]            bus_value,
    output logic [WAYS-1:0]                        ret_valid,
    output logic [WAYS-1:0]                        ret_is_store,
    output logic [WAYS-1:0][PREG_W-1:0]            ret_old_preg,
    output logic [WAYS-1:0][DATA_W-1:0]            ret_addr,
    output logic [WAYS-1:0][DATA_W-1:0]            ret_data,
    output logic                                   flush,
    output logic [31:0]                            stall_cycles,
    output logic [31:0]                            bus_beats
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int WW = $clog2(WAYS + 1);
    localparam int BW = $clog2(NBUS);
    localparam int CW = $clog2(NBUS + 1);

    slot_t [DEPTH-1:0]          ring;
    logic  [PW-1:0]             head_q, tail_q;
    logic  [PW-1:0]             count, free_n;
    logic  [DEPTH-1:0]          done_v, misp_v;
    logic  [DEPTH-1:0][1:0]     kind_v;
    logic  [NSRC-1:0][BW-1:0]   src_slot;
    logic  [CW-1:0]             wb_used;
    logic  [WAYS-1:0]           ret_sel, ret_bus;
    logic  [WW-1:0]             ret_n;
    logic  [WAYS-1:0][AW-1:0]   ridx;
    int                         nxt;

    assign count  = tail_q - head_q;
    assign free_n = PW'(DEPTH) - count;

    always_comb begin
        if (flush)                              alloc_grant = '0;
        else if (int'(alloc_req) > int'(free_n)) alloc_grant = WW'(free_n);
        else                                    alloc_grant = alloc_req;
    end

    for (genvar i = 0; i < WAYS; i++) begin : g_lane
        assign alloc_tag[i]    = tail_q[AW-1:0] + AW'(i);
        assign ridx[i]         = head_q[AW-1:0] + AW'(i);
        assign ret_is_store[i] = ring[ridx[i]].kind == K_STORE;
        assign ret_old_preg[i] = ring[ridx[i]].old;
        assign ret_addr[i]     = ring[ridx[i]].addr;
        assign ret_data[i]     = ring[ridx[i]].value;
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_flags
        assign done_v[e] = ring[e].done;
        assign misp_v[e] = ring[e].mispred;
        assign kind_v[e] = ring[e].kind;
    end

    ring_bus_arbiter #(.NSRC(NSRC), .NBUS(NBUS)) u_arb (
        .req  (wb_valid),
        .gnt  (wb_ready),
        .slot (src_slot),
        .used (wb_used)
    );

    ring_retire_pick #(.DEPTH(DEPTH), .WAYS(WAYS), .NBUS(NBUS)) u_pick (
        .head_idx (head_q[AW-1:0]),
        .count    (count),
        .done     (done_v),
        .mispred  (misp_v),
        .kind     (kind_v),
        .bus_free (CW'(NBUS) - wb_used),
        .ret      (ret_sel),
        .use_bus  (ret_bus),
        .ret_n    (ret_n),
        .flush    (flush)
    );

    assign ret_valid = ret_sel;

    always_comb begin
        bus_valid    = '0;
        bus_from_rob = '0;
        bus_tag      = '0;
        bus_preg     = '0;
        bus_value    = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (wb_ready[s]) begin
                bus_valid[src_slot[s]] = 1'b1;
                bus_tag[src_slot[s]]   = wb_tag[s];
                bus_preg[src_slot[s]]  = wb_preg[s];
                bus_value[src_slot[s]] = wb_value[s];
            end
        end
        nxt = int'(wb_used);
        for (int k = 0; k < WAYS; k++) begin
            if (ret_bus[k]) begin
                bus_valid[BW'(nxt)]    = 1'b1;
                bus_from_rob[BW'(nxt)] = 1'b1;
                bus_tag[BW'(nxt)]      = ridx[k];
                bus_preg[BW'(nxt)]     = ring[ridx[k]].dest;
                bus_value[BW'(nxt)]    = ring[ridx[k]].value;
                nxt = nxt + 1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q       <= '0;
            tail_q       <= '0;
            stall_cycles <= '0;
            bus_beats    <= '0;
            for (int e = 0; e < DEPTH; e++) ring[e] <= '0;
        end else begin
            for (int s = 0; s < NSRC; s++) begin
                if (wb_ready[s]) begin
                    ring[wb_tag[s]].done    <= 1'b1;
                    ring[wb_tag[s]].mispred <= wb_mispred[s];
                    ring[wb_tag[s]].value   <= wb_value[s];
                    ring[wb_tag[s]].addr    <= wb_addr[s];
                end
            end
            for (int i = 0; i < WAYS; i++) begin
                if (WW'(i) < alloc_grant) begin
                    ring[alloc_tag[i]] <= '{done: 1'b0, mispred: 1'b0,
                                            kind: slot_kind_e'(alloc_kind[i]),
                                            dest: alloc_dest[i], old: alloc_old[i],
                                            value: '0, addr: '0};
                end
            end
            head_q <= head_q + PW'(ret_n);
            tail_q <= flush ? head_q + PW'(ret_n) : tail_q + PW'(alloc_grant);
            if (alloc_req > alloc_grant) stall_cycles <= stall_cycles + 32'd1;
            bus_beats <= bus_beats + 32'($countones(bus_valid));
        end
    end
endmodule

// File: rtl/reorder_ring_checks.sv
module reorder_ring_checks #(
    parameter int DEPTH = 16,
    parameter int WAYS  = 4,
    parameter int NBUS  = 4,
    parameter int NSRC  = 6
) (
    input logic                          clk,
    input logic                          rst,
    input logic [$clog2(DEPTH):0]        head_q,
    input logic [$clog2(DEPTH):0]        tail_q,
    input logic [$clog2(WAYS+1)-1:0]     alloc_req,
    input logic [$clog2(WAYS+1)-1:0]     alloc_grant,
    input logic [NSRC-1:0]               wb_valid,
    input logic [NSRC-1:0]               wb_ready,
    input logic [NBUS-1:0]               bus_valid,
    input logic [NBUS-1:0]               bus_from_rob,
    input logic [WAYS-1:0]               ret_valid,
    input logic                          flush
);
    localparam int PW = $clog2(DEPTH) + 1;

    a_r10_occupancy: assert property (@(posedge clk) disable iff (rst)
        (tail_q - head_q) <= PW'(DEPTH));

    a_r2_grant_le_req: assert property (@(posedge clk) disable iff (rst)
        alloc_grant <= alloc_req);

    a_r2_grant_le_free: assert property (@(posedge clk) disable iff (rst)
        int'(alloc_grant) <= DEPTH - int'(tail_q - head_q));

    a_r4_ready_only_valid: assert property (@(posedge clk) disable iff (rst)
        (wb_ready & ~wb_valid) == '0);

    a_r4_loser_only_when_full: assert property (@(posedge clk) disable iff (rst)
        (|(wb_valid & ~wb_ready)) |-> ($countones(wb_ready) == NBUS));

    a_r5_rob_after_writeback: assert property (@(posedge clk) disable iff (rst)
        (|bus_from_rob) |-> ((wb_valid & ~wb_ready) == '0));

    a_r5_rob_bus_driven: assert property (@(posedge clk) disable iff (rst)
        (bus_from_rob & ~bus_valid) == '0);

    for (genvar k = 1; k < WAYS; k++) begin : g_prefix
        a_r6_in_order: assert property (@(posedge clk) disable iff (rst)
            ret_valid[k] |-> ret_valid[k-1]);
    end

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (tail_q == head_q));

    a_r8_no_alloc_on_flush: assert property (@(posedge clk) disable iff (rst)
        flush |-> (alloc_grant == '0));
endmodule

bind reorder_ring reorder_ring_checks #(
    .DEPTH(DEPTH), .WAYS(WAYS), .NBUS(NBUS), .NSRC(NSRC)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .head_q       (head_q),
    .tail_q       (tail_q),
    .alloc_req    (alloc_req),
    .alloc_grant  (alloc_grant),
    .wb_valid     (wb_valid),
    .wb_ready     (wb_ready),
    .bus_valid    (bus_valid),
    .bus_from_rob (bus_from_rob),
    .ret_valid    (ret_valid),
    .flush        (flush)
);

// File: tb/sim_reorder_ring.sv
module sim_reorder_ring;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [2:0]        alloc_req;
    logic [3:0][1:0]   alloc_kind;
    logic [3:0][4:0]   alloc_dest, alloc_old;
    logic [2:0]        alloc_grant;
    logic [3:0][3:0]   alloc_tag;
    logic [5:0]        wb_valid, wb_mispred, wb_ready;
    logic [5:0][3:0]   wb_tag;
    logic [5:0][4:0]   wb_preg;
    logic [5:0][31:0]  wb_value, wb_addr;
    logic [3:0]        bus_valid, bus_from_rob;
    logic [3:0][3:0]   bus_tag;
    logic [3:0][4:0]   bus_preg;
    logic [3:0][31:0]  bus_value;
    logic [3:0]        ret_valid, ret_is_store;
    logic [3:0][4:0]   ret_old_preg;
    logic [3:0][31:0]  ret_addr, ret_data;
    logic              flush;
    logic [31:0]       stall_cycles, bus_beats;

    reorder_ring u0 (.*);

    typedef struct { int old; bit st; int addr; int data; } exp_t;
    exp_t q[$];
    int checks = 0;
    int fails  = 0;

    task automatic chk(input string rq, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, got, exp);
        end
    endtask

    task automatic clr();
        alloc_req = '0; alloc_kind = '0; alloc_dest = '0; alloc_old = '0;
        wb_valid = '0; wb_mispred = '0; wb_tag = '0; wb_preg = '0;
        wb_value = '0; wb_addr = '0;
    endtask

    // driver: request n slots, push the ones expected to retire
    task automatic alloc(input int n, input int k0, input int k1, input int old0, input int keep);
        alloc_req = 3'(n);
        for (int i = 0; i < 4; i++) begin
            alloc_kind[i] = (i == 0) ? 2'(k0) : (i == 1) ? 2'(k1) : 2'd0;
            alloc_old[i]  = 5'(old0 + i);
            alloc_dest[i] = 5'((old0 + i + 16) % 32);
        end
        for (int i = 0; i < keep; i++) q.push_back('{old0 + i, (i == 0 && k0 == 1), 0, 0});
    endtask

    task automatic wb(input int src, input int tag, input int val, input int adr, input bit mp);
        wb_valid[src]   = 1'b1;
        wb_tag[src]     = 4'(tag);
        wb_preg[src]    = 5'(tag);
        wb_value[src]   = 32'(val);
        wb_addr[src]    = 32'(adr);
        wb_mispred[src] = mp;
    endtask

    task automatic cyc();
        @(negedge clk);
        clr();
    endtask

    // monitor: compares every retirement against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (!rst) begin
                for (int k = 0; k < 4; k++) begin
                    if (ret_valid[k]) begin
                        if (q.size() == 0) chk("R6", "unexpected retire", 1, 0);
                        else begin
                            exp_t e;
                            e = q.pop_front();
                            chk("R6", "retire old preg", ret_old_preg[k], e.old);
                            chk("R7", "retire store flag", ret_is_store[k], e.st);
                            if (e.st) begin
                                chk("R7", "store addr", ret_addr[k], 64);
                                chk("R7", "store data", ret_data[k], 55);
                            end
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        chk("R1", "grant idle", alloc_grant, 0);
        chk("R1", "bus idle", bus_valid, 0);
        chk("R1", "no retire", ret_valid, 0);
        chk("R1", "flush low", flush, 0);
        chk("R1", "stall count", stall_cycles, 0);
        chk("R1", "beat count", bus_beats, 0);

        // fill all 16 slots with register kind
        cyc(); alloc(4, 0, 0, 0, 4); #5;
        chk("R2", "grant 4", alloc_grant, 4);
        chk("R2", "tag0", alloc_tag[0], 0);
        chk("R2", "tag3", alloc_tag[3], 3);
        cyc(); alloc(4, 0, 0, 4, 4); #5;
        chk("R2", "tag base 4", alloc_tag[0], 4);
        cyc(); alloc(4, 0, 0, 8, 4); #5;
        cyc(); alloc(4, 0, 0, 12, 4); #5;
        chk("R2", "tag 15", alloc_tag[3], 15);
        cyc(); alloc(4, 0, 0, 0, 0); #5;
        chk("R10", "full grant", alloc_grant, 0);

        // six writebacks contend for four buses
        cyc();
        for (int s = 0; s < 6; s++) wb(s, s, 100 + s, 0, 1'b0);
        #5;
        chk("R3", "stall after full", stall_cycles, 1);
        chk("R4", "ready mask", wb_ready, 6'b001111);
        chk("R5", "all buses wb", bus_valid, 4'b1111);
        chk("R5", "no rob bus", bus_from_rob, 0);
        chk("R5", "bus3 tag", bus_tag[3], 3);

        // losers retry; two buses left for retirement
        cyc(); wb(4, 4, 104, 0, 1'b0); wb(5, 5, 105, 0, 1'b0); #5;
        chk("R4", "retry ready", wb_ready, 6'b110000);
        chk("R7", "retire limited by buses", ret_valid, 4'b0011);
        chk("R5", "rob buses", bus_from_rob, 4'b1100);
        chk("R5", "rob bus tag", bus_tag[2], 0);
        chk("R5", "rob bus preg", bus_preg[2], 16);
        chk("R5", "rob bus value", bus_value[2], 100);

        cyc(); #5;
        chk("R6", "retire four", ret_valid, 4'b1111);
        chk("R9", "beats after two cycles", bus_beats, 8);

        cyc(); wb(0, 7, 107, 0, 1'b0); #5;
        chk("R6", "head not done", ret_valid, 0);
        cyc(); wb(0, 6, 106, 0, 1'b0); #5;
        chk("R6", "stop at slot 6", ret_valid, 0);
        chk("R9", "beats accumulate", bus_beats, 13);
        cyc(); #5;
        chk("R6", "retire two then stop", ret_valid, 4'b0011);

        // wrap: store, mispredicted branch, two younger register slots
        cyc(); alloc(4, 1, 2, 20, 2); #5;
        chk("R2", "wrap grant", alloc_grant, 4);
        chk("R2", "wrap tag", alloc_tag[0], 0);
        cyc(); for (int s = 0; s < 4; s++) wb(s, 8 + s, 108 + s, 0, 1'b0); #5;
        cyc(); for (int s = 0; s < 4; s++) wb(s, 12 + s, 112 + s, 0, 1'b0); #5;
        chk("R7", "buses taken by writeback", ret_valid, 0);
        cyc();
        wb(0, 0, 55, 64, 1'b0); wb(1, 1, 0, 0, 1'b1);
        wb(2, 2, 1, 0, 1'b0); wb(3, 3, 2, 0, 1'b0);
        #5;
        cyc(); #5;
        chk("R6", "retire 8..11", ret_valid, 4'b1111);
        cyc(); #5;
        chk("R6", "retire 12..15", ret_valid, 4'b1111);
        cyc(); alloc(2, 0, 0, 30, 0); #5;
        chk("R8", "flush", flush, 1);
        chk("R8", "store and branch only", ret_valid, 4'b0011);
        chk("R7", "no bus for store/branch", bus_valid, 0);
        chk("R8", "alloc refused", alloc_grant, 0);
        cyc(); alloc(1, 0, 0, 30, 0); #5;
        chk("R8", "flushed not retired", ret_valid, 0);
        chk("R8", "flush low", flush, 0);
        chk("R8", "tail past branch", alloc_tag[0], 2);
        chk("R8", "grant after flush", alloc_grant, 1);
        cyc(); #5;
        chk("R6", "scoreboard drained", q.size(), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule